// File: doc/BRIEF.md
# Handshaked Iterative GCD Unit

This block computes the greatest common divisor of two unsigned operands by repeated comparison, swapping and subtraction. One pair of operands is processed at a time. The operands arrive on a valid/ready input channel. The result leaves on a separate valid/ready output channel, so either side can stall the unit without losing data.

Internally, a three-state controller (idle, iterating, holding the result) steers a datapath. The datapath has two operand registers, a comparator, a subtractor and the selection muxes. In every iterating cycle the datapath does one of two things. If the first register is smaller than the second, it swaps them. Otherwise, if the second register is nonzero, it replaces the first register with their difference. Once the second register reaches zero, the first register holds the answer.

Top module: `euclid_gcd_unit`

## Requirements
- R1: After a synchronous reset, `in_ready` is 1 and `out_valid` is 0.
- R2: A pair of operands is taken only on a rising edge where `in_valid` and `in_ready` are both 1, and `in_ready` is 0 in the cycle after that edge.
- R3: While an operation is in progress or a result is waiting, `in_ready` stays 0, and any values on `in_valid`, `in_a` and `in_b` have no effect on the result delivered.
- R4: For two nonzero operands, `out_gcd` equals their greatest common divisor when `out_valid` is 1.
- R5: If both operands are zero the result is zero, and if exactly one is zero the result is the other operand.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_gcd` keeps its value on the next cycle.
- R7: After a rising edge with `out_valid` and `out_ready` both 1, `out_valid` is 0 and `in_ready` is 1 in the following cycle.
- R8: `in_ready` and `out_valid` are never 1 together, and both come straight from registered state, so neither depends combinationally on `in_valid` or `out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_a | input | W | First unsigned operand |
| in_b | input | W | Second unsigned operand |
| in_valid | input | 1 | Operand pair is present |
| in_ready | output | 1 | Unit can accept an operand pair |
| out_gcd | output | W | Greatest common divisor |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Downstream accepts the result |

## Verification
The unit is built with a 5-bit width, and every one of the 1024 operand pairs is fed through it. The sweep therefore covers:
- zero operands on either side and on both sides;
- equal pairs;
- coprime pairs;
- pairs whose ratio forces long subtraction runs.

Together these separate the swap path from the subtract path and from the termination test. While each pair is in flight, the bench keeps driving different operands with `in_valid` high, so any operand that is accepted when it should not be shows up as a wrong result. The bench also holds back `out_ready` for a random number of cycles to show that the result stays stable, and checks that the unit is ready again exactly one cycle after each result is taken.

// File: rtl/euclid_gcd_dpath.sv
module euclid_gcd_dpath #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic         run,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         a_lt_b,
  output logic         b_zero,
  output logic [W-1:0] gcd_o
);
  logic [W-1:0] a_q, b_q;
  logic [W-1:0] diff;

  assign a_lt_b = a_q < b_q;
  assign b_zero = (b_q == '0);
  assign diff   = a_q - b_q;
  assign gcd_o  = a_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
    end else if (ld) begin
      a_q <= in_a;
      b_q <= in_b;
    end else if (run) begin
      if (a_lt_b) begin
        a_q <= b_q;
        b_q <= a_q;
      end else if (!b_zero) begin
        a_q <= diff;
      end
    end
  end

  // R4: an iteration step never increases the operand sum
  p_sum_shrinks_r4: assert property (@(posedge clk) disable iff (rst)
    (run && !ld) |=> ({1'b0, a_q} + {1'b0, b_q}) <= ({1'b0, $past(a_q)} + {1'b0, $past(b_q)}));

  // R6: registers are frozen when neither loading nor iterating
  p_hold_regs_r6: assert property (@(posedge clk) disable iff (rst)
    (!run && !ld) |=> ($stable(a_q) && $stable(b_q)));
endmodule

// File: rtl/euclid_gcd_ctrl.sv
module euclid_gcd_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic out_ready,
  input  logic b_zero,
  output logic in_ready,
  output logic out_valid,
  output logic ld,
  output logic run
);
  typedef enum logic [1:0] {S_IDLE = 2'd0, S_CALC = 2'd1, S_DONE = 2'd2} state_t;
  state_t state_q, state_d;

  assign in_ready  = (state_q == S_IDLE);
  assign out_valid = (state_q == S_DONE);
  assign run       = (state_q == S_CALC);
  assign ld        = in_ready && in_valid;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (in_valid)  state_d = S_CALC;
      S_CALC:  if (b_zero)    state_d = S_DONE;
      S_DONE:  if (out_ready) state_d = S_IDLE;
      default:                state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= S_IDLE;
    else     state_q <= state_d;
  end

  // R2: after accepting operands, not ready next cycle
  p_busy_after_load_r2: assert property (@(posedge clk) disable iff (rst)
    ld |=> (run && !in_ready));

  // R3: computing keeps in_ready low until the result leaves
  p_no_ready_while_calc_r3: assert property (@(posedge clk) disable iff (rst)
    (run && !b_zero) |=> !in_ready);
endmodule

// File: rtl/euclid_gcd_unit.sv
module euclid_gcd_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic         in_valid,
  output logic         in_ready,
  output logic [W-1:0] out_gcd,
  output logic         out_valid,
  input  logic         out_ready
);
  logic ld, run, a_lt_b, b_zero;

  euclid_gcd_ctrl u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_ready(out_ready),
    .b_zero(b_zero), .in_ready(in_ready), .out_valid(out_valid),
    .ld(ld), .run(run)
  );

  euclid_gcd_dpath #(.W(W)) u_dpath (
    .clk(clk), .rst(rst), .ld(ld), .run(run), .in_a(in_a), .in_b(in_b),
    .a_lt_b(a_lt_b), .b_zero(b_zero), .gcd_o(out_gcd)
  );

  // R6: result held under backpressure
  p_hold_result_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_gcd)));

  // R7: result taken -> ready again next cycle
  p_release_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> (in_ready && !out_valid));

  // R8: the two channel flags are exclusive
  p_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid));

  // R1: first cycle out of reset is idle
  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> (in_ready && !out_valid));
endmodule

// File: tb/euclid_gcd_unit_tb_top.sv
module euclid_gcd_unit_tb_top;
  localparam int BW = 5;
  localparam int N  = 1 << BW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [BW-1:0] in_a = '0, in_b = '0;
  logic          in_valid = 1'b0, out_ready = 1'b0;
  logic          in_ready, out_valid;
  logic [BW-1:0] out_gcd;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  euclid_gcd_unit #(.W(BW)) dut_i (
    .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b), .in_valid(in_valid),
    .in_ready(in_ready), .out_gcd(out_gcd), .out_valid(out_valid),
    .out_ready(out_ready)
  );

  function automatic int ref_gcd(int x, int y);
    int t;
    while (y != 0) begin
      t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic run_pair(int a, int b);
    int exp, wait_cnt, stall;
    logic [BW-1:0] held;
    exp = ref_gcd(a, b);
    check(in_ready === 1'b1, "R7", int'(in_ready), 1);
    in_a = BW'(a);
    in_b = BW'(b);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    // R2: no longer ready after the accepting edge
    check(in_ready === 1'b0, "R2", int'(in_ready), 0);
    wait_cnt = 0;
    while (out_valid !== 1'b1 && wait_cnt < 4 * N) begin
      // R3: offer other operands while busy; they must be ignored
      check(in_ready === 1'b0, "R3", int'(in_ready), 0);
      in_a = BW'($urandom);
      in_b = BW'($urandom);
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wait_cnt++;
    end
    check(out_valid === 1'b1, "R4", int'(out_valid), 1);
    check(in_ready === 1'b0, "R8", int'(in_ready), 0);
    if (a == 0 || b == 0)
      check(int'(out_gcd) == exp, "R5", int'(out_gcd), exp);
    else
      check(int'(out_gcd) == exp, "R4", int'(out_gcd), exp);
    held = out_gcd;
    stall = int'($urandom_range(0, 2));
    for (int s = 0; s < stall; s++) begin
      in_a = BW'($urandom);
      in_b = BW'($urandom);
      @(posedge clk);
      @(negedge clk);
      check(out_valid === 1'b1 && out_gcd === held, "R6", int'(out_gcd), int'(held));
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    check(out_valid === 1'b0, "R7", int'(out_valid), 0);
    check(in_ready === 1'b1, "R7", int'(in_ready), 1);
  endtask

  initial begin
    #(20 * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(in_ready === 1'b1, "R1", int'(in_ready), 1);
    check(out_valid === 1'b0, "R1", int'(out_valid), 0);
    for (int a = 0; a < N; a++)
      for (int b = 0; b < N; b++)
        run_pair(a, b);
    finish_run();
  end
endmodule